// File: doc/BRIEF.md
# Secure Gateway Entry Integrity Checker

This block sequences the admission of a call from the non-secure world into the secure world, after a gateway instruction has been recognised by the decoder. On a start pulse it captures the caller's link register, the secure control register, the trap-enable setting and the two secure stack pointers. When the security extension is present and the core is in thread mode, it takes the active secure stack pointer and sends that address to an external address-check unit. If the check passes, it reads one word from the stack through a valid/ready memory port. A failed access is sorted into one of three fault classes. Each class sets sticky status bits in its own register, loads its own fault address register and pends its own exception.

When trap-enable is set, the loaded word is compared with a fixed integrity signature, and one gating bit of the secure control register is examined. Either condition turns the entry into an invalid-entry-point fault. A successful entry ends with a one-cycle done pulse, a secure-switch strobe, the link-register bit 0 cleared and the secure floating-point-active flag cleared. An aborted entry leaves the link and control values as they were captured.

Top module: `sg_entry_guard`

## Requirements
- R1: After reset, done_o, secure_switch_o, chk_req_o, mem_req_valid_o and every pend output are low, and all fault status and fault address outputs are zero.
- R2: If sec_ext_i is low or handler_i is high when start_i is sampled, no address check and no memory request are made, and the next cycle shows done_o with result_o = 0 (OK).
- R3: The stack address on chk_addr_o and mem_addr_o is psp_s_i when use_psp_i was high at start, and msp_s_i otherwise. Start-time inputs are captured, so later changes have no effect.
- R4: On the checked path the stack word is always read, even with trap_en_i low. With trap_en_i low, any loaded word gives result 0 (OK).
- R5: An attribution violation (chk_attr_viol_i) gives result_o = 1. It ORs 2'b11 (bit 0 violation, bit 1 address valid) into sec_stat_o, loads sec_far_o with the stack address, pulses pend_sec_o with done_o, and issues no memory request.
- R6: A non-attribution violation (chk_other_viol_i with chk_attr_viol_i low) gives result_o = 2. It ORs 2'b11 into mm_stat_o, loads mm_far_o and pulses pend_mem_o. When both flags are set, the attribution violation wins.
- R7: A memory response with mem_rsp_err_i gives result_o = 3. It ORs 2'b11 into bus_stat_o, loads bus_far_o and pulses pend_bus_o.
- R8: With trap_en_i high, result_o = 4 (invalid entry point), with no fault register change and no pend, if the loaded word with bit 0 masked equals 32'hFEFA125A, or if bit 0 of the captured ctrl_s_i is 0.
- R9: On success, done_o, result_o = 0 and secure_switch_o occur together. lr_o equals the captured lr_i with bit 0 cleared, and ctrl_s_o equals the captured ctrl_s_i with bit 3 cleared.
- R10: On any abort (result 1 to 4), secure_switch_o stays low, and lr_o and ctrl_s_o equal the captured values unchanged.
- R11: Fault status bits are sticky across entries. Each fault address register is overwritten by the most recent fault of its class.
- R12: done_o lasts exactly one cycle. After a memory request is accepted, no further request is made until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Gateway instruction executed from non-secure state |
| sec_ext_i | input | 1 | Security extension present |
| handler_i | input | 1 | Core is in handler mode |
| use_psp_i | input | 1 | Secure process stack selected |
| psp_s_i | input | AW | Secure process stack pointer |
| msp_s_i | input | AW | Secure main stack pointer |
| trap_en_i | input | 1 | Integrity trap enable |
| lr_i | input | DW | Link register value |
| ctrl_s_i | input | CTRL_W | Secure control register value |
| chk_req_o | output | 1 | Address-check request |
| chk_addr_o | output | AW | Address to check |
| chk_rsp_valid_i | input | 1 | Address-check result valid |
| chk_attr_viol_i | input | 1 | Security attribution violation |
| chk_other_viol_i | input | 1 | Other protection violation |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_addr_o | output | AW | Memory read address |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_err_i | input | 1 | Memory response bus error |
| mem_rsp_data_i | input | DW | Memory read data |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | 0 OK, 1 secure fault, 2 memory-manage, 3 bus fault, 4 invalid entry |
| secure_switch_o | output | 1 | Switch to secure state |
| lr_o | output | DW | Resulting link register value |
| ctrl_s_o | output | CTRL_W | Resulting secure control register value |
| pend_sec_o | output | 1 | Pend secure fault |
| pend_mem_o | output | 1 | Pend memory-manage fault |
| pend_bus_o | output | 1 | Pend bus fault |
| sec_stat_o | output | 2 | Secure fault status {address valid, violation} |
| sec_far_o | output | AW | Secure fault address |
| mm_stat_o | output | 2 | Memory-manage status {address valid, violation} |
| mm_far_o | output | AW | Memory-manage fault address |
| bus_stat_o | output | 2 | Bus fault status {address valid, violation} |
| bus_far_o | output | AW | Bus fault address |

## Verification
The assertions assume well-behaved neighbours. Start arrives only while the block is idle. The address checker answers only while a check is requested. The memory returns a response only for an accepted request, and one response per request. The bench models the checker and the memory under exactly these rules, with random response delays and random ready stalls, and it raises start only after the previous done pulse has gone. Random start-time values, signature hits with and without bit 0 set, and mixed violation flags then cover every fault class and the success path.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ADDR_CHECK = 3'd1,
        ST_MEM_READ   = 3'd2,
        ST_EVALUATE   = 3'd3,
        ST_DONE_OK    = 3'd4,
        ST_DONE_FAULT = 3'd5
    } sg_state_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_SECFLT  = 3'd1,
        RES_MEMMAN  = 3'd2,
        RES_BUSFLT  = 3'd3,
        RES_INVEP   = 3'd4
    } sg_res_e;

    typedef enum logic [1:0] {
        CLS_SEC = 2'd0,
        CLS_MEM = 2'd1,
        CLS_BUS = 2'd2
    } sg_cls_e;

    // status field: bit 0 violation, bit 1 address valid
    localparam logic [1:0] STAT_SET = 2'b11;
    localparam logic [31:0] SG_SIGNATURE = 32'hFEFA_125A;
endpackage

// File: rtl/sg_sp_sel.sv
module sg_sp_sel #(
    parameter int AW = 32
) (
    input  logic          use_psp_i,
    input  logic [AW-1:0] psp_i,
    input  logic [AW-1:0] msp_i,
    output logic [AW-1:0] sp_o
);
    always_comb begin
        sp_o = use_psp_i ? psp_i : msp_i;
    end
endmodule

// File: rtl/sg_sig_cmp.sv
module sg_sig_cmp #(
    parameter int          DW  = 32,
    parameter logic [DW-1:0] SIG = '0
) (
    input  logic [DW-1:0] word_i,
    output logic          hit_o
);
    localparam logic [DW-1:0] LSB_MASK = {{(DW-1){1'b1}}, 1'b0};

    always_comb begin
        hit_o = ((word_i & LSB_MASK) == (SIG & LSB_MASK));
    end
endmodule

// File: rtl/sg_fault_bank.sv
module sg_fault_bank
    import sg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_en_i,
    input  sg_cls_e       rec_cls_i,
    input  logic [AW-1:0] rec_addr_i,
    output logic [1:0]    sec_stat_o,
    output logic [AW-1:0] sec_far_o,
    output logic [1:0]    mm_stat_o,
    output logic [AW-1:0] mm_far_o,
    output logic [1:0]    bus_stat_o,
    output logic [AW-1:0] bus_far_o
);
    typedef struct packed {
        logic [1:0]    sec_stat;
        logic [AW-1:0] sec_far;
        logic [1:0]    mm_stat;
        logic [AW-1:0] mm_far;
        logic [1:0]    bus_stat;
        logic [AW-1:0] bus_far;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (rec_en_i) begin
            case (rec_cls_i)
                CLS_SEC: begin
                    bank_d.sec_stat = bank_q.sec_stat | STAT_SET;
                    bank_d.sec_far  = rec_addr_i;
                end
                CLS_MEM: begin
                    bank_d.mm_stat = bank_q.mm_stat | STAT_SET;
                    bank_d.mm_far  = rec_addr_i;
                end
                CLS_BUS: begin
                    bank_d.bus_stat = bank_q.bus_stat | STAT_SET;
                    bank_d.bus_far  = rec_addr_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign sec_stat_o = bank_q.sec_stat;
    assign sec_far_o  = bank_q.sec_far;
    assign mm_stat_o  = bank_q.mm_stat;
    assign mm_far_o   = bank_q.mm_far;
    assign bus_stat_o = bank_q.bus_stat;
    assign bus_far_o  = bank_q.bus_far;

    // R11: status bits once set never drop
    p_sticky_sec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stat_o & $past(sec_stat_o)) == $past(sec_stat_o));
    p_sticky_mm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_stat_o & $past(mm_stat_o)) == $past(mm_stat_o));
    p_sticky_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stat_o & $past(bus_stat_o)) == $past(bus_stat_o));
    // R11: an address register moves only when its class is recorded
    p_far_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rec_en_i) |-> ($stable(sec_far_o) && $stable(mm_far_o) && $stable(bus_far_o)));
endmodule

// File: rtl/sg_entry_guard.sv
module sg_entry_guard
    import sg_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int CTRL_W   = 4,
    parameter int SFPA_BIT = 3,
    parameter int GATE_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sec_ext_i,
    input  logic              handler_i,
    input  logic              use_psp_i,
    input  logic [AW-1:0]     psp_s_i,
    input  logic [AW-1:0]     msp_s_i,
    input  logic              trap_en_i,
    input  logic [DW-1:0]     lr_i,
    input  logic [CTRL_W-1:0] ctrl_s_i,
    output logic              chk_req_o,
    output logic [AW-1:0]     chk_addr_o,
    input  logic              chk_rsp_valid_i,
    input  logic              chk_attr_viol_i,
    input  logic              chk_other_viol_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic              mem_rsp_err_i,
    input  logic [DW-1:0]     mem_rsp_data_i,
    output logic              done_o,
    output logic [2:0]        result_o,
    output logic              secure_switch_o,
    output logic [DW-1:0]     lr_o,
    output logic [CTRL_W-1:0] ctrl_s_o,
    output logic              pend_sec_o,
    output logic              pend_mem_o,
    output logic              pend_bus_o,
    output logic [1:0]        sec_stat_o,
    output logic [AW-1:0]     sec_far_o,
    output logic [1:0]        mm_stat_o,
    output logic [AW-1:0]     mm_far_o,
    output logic [1:0]        bus_stat_o,
    output logic [AW-1:0]     bus_far_o
);
    localparam logic [DW-1:0]     LR_CLR   = {{(DW-1){1'b1}}, 1'b0};
    localparam logic [CTRL_W-1:0] FPA_CLR  = ~(CTRL_W'(1) << SFPA_BIT);
    localparam logic [DW-1:0]     SIG_WORD = DW'(SG_SIGNATURE);

    typedef struct packed {
        sg_state_e         st;
        sg_res_e           code;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     lr;
        logic [CTRL_W-1:0] ctrl;
        logic              trap;
        logic [DW-1:0]     word;
        logic              issued;
    } ctx_t;

    ctx_t    ctx_d, ctx_q;
    logic [AW-1:0] sp_sel;
    logic    sig_hit;
    logic    rec_en;
    sg_cls_e rec_cls;

    sg_sp_sel #(.AW(AW)) u_sp_sel (
        .use_psp_i (use_psp_i),
        .psp_i     (psp_s_i),
        .msp_i     (msp_s_i),
        .sp_o      (sp_sel)
    );

    sg_sig_cmp #(.DW(DW), .SIG(SIG_WORD)) u_sig_cmp (
        .word_i (ctx_q.word),
        .hit_o  (sig_hit)
    );

    sg_fault_bank #(.AW(AW)) u_fault_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_en_i   (rec_en),
        .rec_cls_i  (rec_cls),
        .rec_addr_i (ctx_q.addr),
        .sec_stat_o (sec_stat_o),
        .sec_far_o  (sec_far_o),
        .mm_stat_o  (mm_stat_o),
        .mm_far_o   (mm_far_o),
        .bus_stat_o (bus_stat_o),
        .bus_far_o  (bus_far_o)
    );

    always_comb begin
        ctx_d   = ctx_q;
        rec_en  = 1'b0;
        rec_cls = CLS_SEC;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.addr   = sp_sel;
                    ctx_d.lr     = lr_i;
                    ctx_d.ctrl   = ctrl_s_i;
                    ctx_d.trap   = trap_en_i;
                    ctx_d.issued = 1'b0;
                    ctx_d.code   = RES_OK;
                    ctx_d.st     = (sec_ext_i && !handler_i) ? ST_ADDR_CHECK : ST_DONE_OK;
                end
            end
            ST_ADDR_CHECK: begin
                if (chk_rsp_valid_i) begin
                    if (chk_attr_viol_i) begin
                        ctx_d.code = RES_SECFLT;
                        ctx_d.st   = ST_DONE_FAULT;
                        rec_en     = 1'b1;
                        rec_cls    = CLS_SEC;
                    end else if (chk_other_viol_i) begin
                        ctx_d.code = RES_MEMMAN;
                        ctx_d.st   = ST_DONE_FAULT;
                        rec_en     = 1'b1;
                        rec_cls    = CLS_MEM;
                    end else begin
                        ctx_d.st   = ST_MEM_READ;
                    end
                end
            end
            ST_MEM_READ: begin
                if (!ctx_q.issued) begin
                    if (mem_req_ready_i) ctx_d.issued = 1'b1;
                end else if (mem_rsp_valid_i) begin
                    ctx_d.issued = 1'b0;
                    if (mem_rsp_err_i) begin
                        ctx_d.code = RES_BUSFLT;
                        ctx_d.st   = ST_DONE_FAULT;
                        rec_en     = 1'b1;
                        rec_cls    = CLS_BUS;
                    end else begin
                        ctx_d.word = mem_rsp_data_i;
                        ctx_d.st   = ST_EVALUATE;
                    end
                end
            end
            ST_EVALUATE: begin
                if (ctx_q.trap && (sig_hit || !ctx_q.ctrl[GATE_BIT])) begin
                    ctx_d.code = RES_INVEP;
                    ctx_d.st   = ST_DONE_FAULT;
                end else begin
                    ctx_d.st   = ST_DONE_OK;
                end
            end
            ST_DONE_OK, ST_DONE_FAULT: ctx_d.st = ST_IDLE;
            default:                   ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    always_comb begin
        chk_req_o       = (ctx_q.st == ST_ADDR_CHECK);
        chk_addr_o      = ctx_q.addr;
        mem_req_valid_o = (ctx_q.st == ST_MEM_READ) && !ctx_q.issued;
        mem_addr_o      = ctx_q.addr;
        done_o          = (ctx_q.st == ST_DONE_OK) || (ctx_q.st == ST_DONE_FAULT);
        result_o        = ctx_q.code;
        secure_switch_o = (ctx_q.st == ST_DONE_OK);
        lr_o            = secure_switch_o ? (ctx_q.lr & LR_CLR) : ctx_q.lr;
        ctrl_s_o        = secure_switch_o ? (ctx_q.ctrl & FPA_CLR) : ctx_q.ctrl;
        pend_sec_o      = (ctx_q.st == ST_DONE_FAULT) && (ctx_q.code == RES_SECFLT);
        pend_mem_o      = (ctx_q.st == ST_DONE_FAULT) && (ctx_q.code == RES_MEMMAN);
        pend_bus_o      = (ctx_q.st == ST_DONE_FAULT) && (ctx_q.code == RES_BUSFLT);
    end

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R12: an accepted read is not re-requested before its response
    p_one_inflight_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);
    // R4: a read is only launched right after a passed address check
    p_read_after_chk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid_o) |-> $past(chk_req_o && chk_rsp_valid_i));
    // R3: checked address does not move while the check is pending
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req_o && $past(chk_req_o)) |-> $stable(chk_addr_o));
    // R9: the switch strobe only accompanies a successful completion
    p_switch_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        secure_switch_o |-> (done_o && result_o == 3'd0));
    // R5..R7: at most one exception pended, and only with done
    p_pend_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_sec_o, pend_mem_o, pend_bus_o}));
    p_pend_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_sec_o || pend_mem_o || pend_bus_o) |-> (done_o && !secure_switch_o));
    // R8: an invalid-entry abort leaves the fault registers alone
    p_invep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 3'd4) |-> ($stable(sec_stat_o) && $stable(mm_stat_o) && $stable(bus_stat_o)));
endmodule

// File: tb/sg_entry_guard_tb.sv
module sg_entry_guard_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam logic [31:0] SIG = 32'hFEFA125A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start_i = 0, sec_ext_i = 0, handler_i = 0, use_psp_i = 0, trap_en_i = 0;
    logic [AW-1:0] psp_s_i = '0, msp_s_i = '0;
    logic [DW-1:0] lr_i = '0;
    logic [CW-1:0] ctrl_s_i = '0;
    logic chk_req_o; logic [AW-1:0] chk_addr_o;
    logic chk_rsp_valid_i = 0, chk_attr_viol_i = 0, chk_other_viol_i = 0;
    logic mem_req_valid_o; logic mem_req_ready_i = 0; logic [AW-1:0] mem_addr_o;
    logic mem_rsp_valid_i = 0, mem_rsp_err_i = 0; logic [DW-1:0] mem_rsp_data_i = '0;
    logic done_o, secure_switch_o, pend_sec_o, pend_mem_o, pend_bus_o;
    logic [2:0] result_o;
    logic [DW-1:0] lr_o; logic [CW-1:0] ctrl_s_o;
    logic [1:0] sec_stat_o, mm_stat_o, bus_stat_o;
    logic [AW-1:0] sec_far_o, mm_far_o, bus_far_o;

    sg_entry_guard #(.AW(AW), .DW(DW), .CTRL_W(CW)) u_dut (.*);

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // scenario
    logic s_handler, s_secext, s_psp_sel, s_trap, s_buserr;
    logic [AW-1:0] s_psp, s_msp;
    logic [DW-1:0] s_lr, s_data;
    logic [CW-1:0] s_ctrl;
    logic [1:0] s_chk;   // bit0 attribution, bit1 other
    // shadow fault registers
    logic [1:0] e_sec_stat = 0, e_mm_stat = 0, e_bus_stat = 0;
    logic [AW-1:0] e_sec_far = 0, e_mm_far = 0, e_bus_far = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_result();
        if (!s_secext || s_handler) return 3'd0;
        if (s_chk[0]) return 3'd1;
        if (s_chk[1]) return 3'd2;
        if (s_buserr) return 3'd3;
        if (s_trap && (((s_data & ~32'd1) == SIG) || !s_ctrl[0])) return 3'd4;
        return 3'd0;
    endfunction

    task automatic run_entry();
        logic saw_chk = 0, saw_mem = 0, got = 0, mem_pend = 0;
        logic [AW-1:0] a_chk = 0, a_mem = 0;
        int chk_wait = $urandom % 3, mem_wait = 0;
        logic [2:0] r_res = 0; logic r_sw = 0, r_ps = 0, r_pm = 0, r_pb = 0;
        logic [DW-1:0] r_lr = 0; logic [CW-1:0] r_ctrl = 0;
        logic [2:0] er = exp_result();
        logic [AW-1:0] sp = s_psp_sel ? s_psp : s_msp;
        bit path = s_secext && !s_handler;
        sec_ext_i = s_secext; handler_i = s_handler; use_psp_i = s_psp_sel;
        psp_s_i = s_psp; msp_s_i = s_msp; trap_en_i = s_trap; lr_i = s_lr; ctrl_s_i = s_ctrl;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        // R3: later input changes must not matter
        psp_s_i = ~s_psp; msp_s_i = ~s_msp; lr_i = $urandom; ctrl_s_i = ~s_ctrl;
        use_psp_i = ~s_psp_sel; trap_en_i = ~s_trap;
        for (int cyc = 0; cyc < 80 && !got; cyc++) begin
            if (done_o) begin
                got = 1; r_res = result_o; r_sw = secure_switch_o; r_lr = lr_o; r_ctrl = ctrl_s_o;
                r_ps = pend_sec_o; r_pm = pend_mem_o; r_pb = pend_bus_o;
            end else begin
                chk_rsp_valid_i = 0; chk_attr_viol_i = 0; chk_other_viol_i = 0;
                mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_err_i = 0;
                if (chk_req_o) begin
                    saw_chk = 1; a_chk = chk_addr_o;
                    if (chk_wait == 0) begin
                        chk_rsp_valid_i = 1; chk_attr_viol_i = s_chk[0]; chk_other_viol_i = s_chk[1];
                    end else chk_wait--;
                end
                if (mem_pend) begin
                    if (mem_wait == 0) begin
                        mem_rsp_valid_i = 1; mem_rsp_err_i = s_buserr; mem_rsp_data_i = s_data;
                        mem_pend = 0;
                    end else mem_wait--;
                end else if (mem_req_valid_o) begin
                    saw_mem = 1; a_mem = mem_addr_o;
                    if ($urandom % 2 == 1) begin
                        mem_req_ready_i = 1; mem_pend = 1; mem_wait = $urandom % 3;
                    end
                end
                @(negedge clk);
            end
        end
        chk_rsp_valid_i = 0; chk_attr_viol_i = 0; chk_other_viol_i = 0;
        mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_err_i = 0;
        check("R12 done reached", got, 1);
        // expected fault shadow update
        case (er)
            3'd1: begin e_sec_stat |= 2'b11; e_sec_far = sp; end
            3'd2: begin e_mm_stat |= 2'b11; e_mm_far = sp; end
            3'd3: begin e_bus_stat |= 2'b11; e_bus_far = sp; end
            default: ;
        endcase
        check(er == 1 ? "R5 result" : er == 2 ? "R6 result" : er == 3 ? "R7 result" :
              er == 4 ? "R8 result" : "R9 result", r_res, er);
        check("R2 check port use", saw_chk, path);
        check("R4 stack read made", saw_mem, path && s_chk == 0);
        if (saw_chk) check("R3 check address", a_chk, sp);
        if (saw_mem) check("R3 read address", a_mem, sp);
        if (er == 0) begin
            check("R9 switch", r_sw, 1);
            check("R9 lr bit0 cleared", r_lr, s_lr & ~32'd1);
            check("R9 fp flag cleared", r_ctrl, s_ctrl & 4'b0111);
        end else begin
            check("R10 no switch", r_sw, 0);
            check("R10 lr kept", r_lr, s_lr);
            check("R10 ctrl kept", r_ctrl, s_ctrl);
        end
        check("R5 pend secure", r_ps, er == 1);
        check("R6 pend memmanage", r_pm, er == 2);
        check("R7 pend bus", r_pb, er == 3);
        check("R11 secure status", sec_stat_o, e_sec_stat);
        check("R11 secure address", sec_far_o, e_sec_far);
        check("R11 mm status", mm_stat_o, e_mm_stat);
        check("R11 mm address", mm_far_o, e_mm_far);
        check("R11 bus status", bus_stat_o, e_bus_stat);
        check("R11 bus address", bus_far_o, e_bus_far);
        @(negedge clk);
        check("R12 done one cycle", done_o, 0);
    endtask

    task automatic base();
        s_handler = 0; s_secext = 1; s_psp_sel = 0; s_trap = 0; s_buserr = 0;
        s_psp = 32'h2000_1000; s_msp = 32'h2000_2000; s_lr = 32'h0800_0101;
        s_data = 32'h1234_5678; s_ctrl = 4'b1001; s_chk = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", done_o, 0);
        check("R1 switch", secure_switch_o, 0);
        check("R1 requests", {chk_req_o, mem_req_valid_o}, 0);
        check("R1 pends", {pend_sec_o, pend_mem_o, pend_bus_o}, 0);
        check("R1 status", {sec_stat_o, mm_stat_o, bus_stat_o}, 0);
        check("R1 addresses", {sec_far_o ^ mm_far_o, bus_far_o}, 0);
        rst_n = 1;
        @(negedge clk);
        base(); s_handler = 1; run_entry();                      // R2
        base(); s_secext = 0; s_trap = 1; run_entry();            // R2
        base(); s_psp_sel = 1; run_entry();                       // R3, R9
        base(); s_data = SIG; run_entry();                        // R4 trap off
        base(); s_chk = 2'b01; run_entry();                       // R5
        base(); s_chk = 2'b11; s_msp = 32'h3000_0040; run_entry(); // R6 priority
        base(); s_chk = 2'b10; run_entry();                       // R6
        base(); s_buserr = 1; run_entry();                        // R7
        base(); s_trap = 1; s_data = SIG; run_entry();            // R8
        base(); s_trap = 1; s_data = SIG | 32'd1; run_entry();    // R8
        base(); s_trap = 1; s_ctrl = 4'b1110; run_entry();        // R8 gate bit
        base(); s_trap = 1; s_data = SIG ^ 32'h100; run_entry();  // R9
        base(); s_chk = 2'b10; s_msp = 32'h4000_0008; run_entry(); // R11 overwrite
        for (int i = 0; i < 60; i++) begin
            s_handler = ($urandom % 6 == 0); s_secext = ($urandom % 8 != 0);
            s_psp_sel = $urandom; s_trap = $urandom; s_psp = $urandom; s_msp = $urandom;
            s_lr = $urandom; s_ctrl = $urandom;
            s_chk = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            s_buserr = ($urandom % 5 == 0);
            case ($urandom % 4)
                0: s_data = SIG;
                1: s_data = SIG | 32'd1;
                default: s_data = $urandom;
            endcase
            run_entry();
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule